// File: doc/BRIEF.md
# ADC Mode Control Sequencer

This block holds the 8-bit mode register of an ADC subsystem and sequences the converter through its operations: power-down, idle, continuous conversion, single conversion and four calibration kinds (self offset, self gain, system zero-scale and system full-scale). The filter is modelled only as a stream of result words. The block counts the settled results that it accepts. A single conversion or a calibration finishes on its own after the correct number of results. At that point the operation field drops back to idle, a calibration result is written into the offset or gain register of every enabled channel, and the ready flags are raised.

Software writes the mode register and reads either that register or a status word through a simple register port. Reading the status word clears the ready flags. The analog side receives plain power-down, reset, resistor-path and reference-select controls, together with the effective power mode.

The result input is a valid/ready stream. A word transfers only on a cycle where `res_valid` and `res_ready` are both high. `res_ready` is low in power-down and idle, and also during any cycle in which a register write is presented. The source must hold a word until it transfers, or drop it; words offered while ready is low are never counted. There is no output stream. Calibration writes are one-cycle pulses that cannot be stalled.

Top module: `adc_mode_seq`

## Requirements
- R1: The mode register resets to 0x00 and reads back on `reg_rdata` when `reg_sel`=0. Bit 7 always reads 0, whatever value is written.
- R2: Mode bit 6 drives `gnd_res_sel` and mode bit 5 drives `prec_ref_sel`.
- R3: Bits 4:3 hold the power mode (00 normal, 01 low power, 10 low power plus) and drive `pwr_mode`. A write with code 11 in that field leaves the previous power mode in place, while the other fields of the write still take effect.
- R4: Bits 2:0 hold the operation (000 power-down, 001 continuous, 010 single, 011 idle, 100 self offset, 101 self gain, 110 system zero, 111 system full). Power-down raises `conv_pd` and `conv_rst`. Idle raises only `conv_rst`. All other operations lower both.
- R5: A single conversion completes on its 2nd accepted result if `chop_en` was low when the mode was written, or on its 3rd if it was high. After that clock edge the operation reads idle (011) and conversion-ready is set.
- R6: Continuous mode sets conversion-ready on every accepted result and never leaves continuous mode by itself.
- R7: Self-offset calibration uses the same result count as a single conversion. On completion it pulses `cal_wr_en` equal to `ch_en` for one cycle, with `cal_wr_gain`=0 and `cal_wr_data` equal to the last accepted result. It also sets both ready flags and returns to idle.
- R8: Self-gain and system full-scale calibration each need twice the single-conversion result count (4 with chop off, 6 with chop on). They complete as in R7 but with `cal_wr_gain`=1.
- R9: System zero-scale calibration needs 3 results regardless of chop, then completes as in R7 with `cal_wr_gain`=0.
- R10: With `reg_sel`=1, `reg_rdata` is {6'b0, cal-ready in bit 1, conversion-ready in bit 0}. A read with `reg_rd`=1 and `reg_sel`=1 clears both flags at the clock edge, unless a flag is set by a result in that same cycle, in which case the set takes priority.
- R11: A mode register write aborts any operation in progress: the result count restarts from zero for the newly written operation.
- R12: A result is counted only when `res_valid` and `res_ready` are both high. `res_ready` is low in power-down, in idle, and in any cycle with `reg_wr` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe for the mode register |
| reg_rd | input | 1 | Read strobe (clears flags when reading status) |
| reg_sel | input | 1 | 0 selects mode register, 1 selects status word |
| reg_wdata | input | 8 | Mode register write data |
| reg_rdata | output | 8 | Read data for the selected register |
| res_valid | input | 1 | Filter result word is valid |
| res_ready | output | 1 | Sequencer accepts a result this cycle |
| res_data | input | DW | Filter result word |
| chop_en | input | 1 | Chopping enabled (sampled on mode write) |
| ch_en | input | NCH | Channel enables |
| conv_pd | output | 1 | Power down all converter circuits |
| conv_rst | output | 1 | Hold converter in reset |
| gnd_res_sel | output | 1 | Select resistor path to ground |
| prec_ref_sel | output | 1 | Select precision reference in low-power modes |
| pwr_mode | output | 2 | Effective power mode |
| cal_wr_en | output | NCH | Per-channel calibration register write pulse |
| cal_wr_gain | output | 1 | 1 writes gain register, 0 writes offset register |
| cal_wr_data | output | DW | Calibration value written |
| conv_rdy | output | 1 | Conversion-ready flag |
| cal_rdy | output | 1 | Calibration-ready flag |

## Verification
The assertions check properties that must hold on every cycle. Power-down always implies reset, and `res_ready` is never high while the converter is held in reset. The power mode never shows the undefined code, and reserved bit 7 always reads zero. Every calibration write pulse lasts a single cycle and occurs with both ready flags set. Result counts per operation and chop setting, the return to idle, abort on a write, clear-on-read and the routing of data to the offset or gain register depend on sequences of stimulus, so only the directed scenarios can show them.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [2:0] {
    OP_PDOWN  = 3'b000,
    OP_CONT   = 3'b001,
    OP_SINGLE = 3'b010,
    OP_IDLE   = 3'b011,
    OP_SOFF   = 3'b100,
    OP_SGAIN  = 3'b101,
    OP_SZERO  = 3'b110,
    OP_SFULL  = 3'b111
  } op_t;

  typedef struct packed {
    logic       rsv;
    logic       gnd_res;
    logic       prec_ref;
    logic [1:0] pwr;
    op_t        op;
  } mode_t;

  localparam logic [1:0] PWR_BAD = 2'b11;

  // Number of accepted results an operation needs; 0 means it never self-completes.
  function automatic logic [3:0] results_needed(op_t op, logic chop);
    logic [3:0] base;
    base = chop ? 4'd3 : 4'd2;
    case (op)
      OP_SINGLE, OP_SOFF: results_needed = base;
      OP_SGAIN, OP_SFULL: results_needed = base << 1;
      OP_SZERO:           results_needed = 4'd3;
      default:            results_needed = 4'd0;
    endcase
  endfunction

endpackage

// File: rtl/adc_mode_reg.sv
module adc_mode_reg
  import adc_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [7:0] wdata,
  input  logic       go_idle,
  output mode_t      mode_q
);

  mode_t wr_val;

  always_comb begin
    wr_val          = mode_t'(wdata);
    wr_val.rsv      = 1'b0;
    if (wdata[4:3] == PWR_BAD) wr_val.pwr = mode_q.pwr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
    end else if (wr) begin
      mode_q <= wr_val;
    end else if (go_idle) begin
      mode_q.op <= OP_IDLE;
    end
  end

endmodule

// File: rtl/adc_result_ctr.sv
module adc_result_ctr
  import adc_seq_pkg::*;
#(
  parameter int CW = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  op_t  new_op,
  input  logic chop,
  input  logic acc,
  output logic done
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] need_q;

  assign done = acc && (need_q != '0) && (cnt_q == need_q - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      need_q <= '0;
    end else if (restart) begin
      cnt_q  <= '0;
      need_q <= CW'(results_needed(new_op, chop));
    end else if (done) begin
      cnt_q  <= '0;
      need_q <= '0;
    end else if (acc && need_q != '0) begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/adc_status_flags.sv
module adc_status_flags #(
  parameter int NCH = 2,
  parameter int DW  = 24
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           acc,
  input  logic           done,
  input  logic           is_cont,
  input  logic           is_cal,
  input  logic           is_gain,
  input  logic [DW-1:0]  res_data,
  input  logic [NCH-1:0] ch_en,
  input  logic           rd_clr,
  output logic           conv_rdy,
  output logic           cal_rdy,
  output logic [NCH-1:0] cal_wr_en,
  output logic           cal_wr_gain,
  output logic [DW-1:0]  cal_wr_data
);

  logic conv_set;
  logic cal_set;

  assign conv_set = acc && (is_cont || done);
  assign cal_set  = done && is_cal;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      conv_rdy <= 1'b0;
      cal_rdy  <= 1'b0;
    end else begin
      if (conv_set)    conv_rdy <= 1'b1;
      else if (rd_clr) conv_rdy <= 1'b0;
      if (cal_set)     cal_rdy  <= 1'b1;
      else if (rd_clr) cal_rdy  <= 1'b0;
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cal_wr_en[g] <= 1'b0;
      else        cal_wr_en[g] <= cal_set && ch_en[g];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cal_wr_gain <= 1'b0;
      cal_wr_data <= '0;
    end else if (cal_set) begin
      cal_wr_gain <= is_gain;
      cal_wr_data <= res_data;
    end
  end

endmodule

// File: rtl/adc_mode_seq.sv
module adc_mode_seq
  import adc_seq_pkg::*;
#(
  parameter int NCH = 2,
  parameter int DW  = 24
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_wr,
  input  logic           reg_rd,
  input  logic           reg_sel,
  input  logic [7:0]     reg_wdata,
  output logic [7:0]     reg_rdata,
  input  logic           res_valid,
  output logic           res_ready,
  input  logic [DW-1:0]  res_data,
  input  logic           chop_en,
  input  logic [NCH-1:0] ch_en,
  output logic           conv_pd,
  output logic           conv_rst,
  output logic           gnd_res_sel,
  output logic           prec_ref_sel,
  output logic [1:0]     pwr_mode,
  output logic [NCH-1:0] cal_wr_en,
  output logic           cal_wr_gain,
  output logic [DW-1:0]  cal_wr_data,
  output logic           conv_rdy,
  output logic           cal_rdy
);

  localparam int CW = 4;

  mode_t mode_q;
  logic  acc;
  logic  done;
  logic  active;
  logic  is_gain;

  assign active    = (mode_q.op != OP_PDOWN) && (mode_q.op != OP_IDLE);
  assign res_ready = active && !reg_wr;
  assign acc       = res_valid && res_ready;
  assign is_gain   = (mode_q.op == OP_SGAIN) || (mode_q.op == OP_SFULL);

  assign conv_pd      = (mode_q.op == OP_PDOWN);
  assign conv_rst     = (mode_q.op == OP_PDOWN) || (mode_q.op == OP_IDLE);
  assign gnd_res_sel  = mode_q.gnd_res;
  assign prec_ref_sel = mode_q.prec_ref;
  assign pwr_mode     = mode_q.pwr;
  assign reg_rdata    = reg_sel ? {6'b0, cal_rdy, conv_rdy} : mode_q;

  adc_mode_reg u_mode (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (reg_wr),
    .wdata   (reg_wdata),
    .go_idle (done),
    .mode_q  (mode_q)
  );

  adc_result_ctr #(.CW(CW)) u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (reg_wr),
    .new_op  (op_t'(reg_wdata[2:0])),
    .chop    (chop_en),
    .acc     (acc),
    .done    (done)
  );

  adc_status_flags #(.NCH(NCH), .DW(DW)) u_flags (
    .clk         (clk),
    .rst_n       (rst_n),
    .acc         (acc),
    .done        (done),
    .is_cont     (mode_q.op == OP_CONT),
    .is_cal      (mode_q.op[2]),
    .is_gain     (is_gain),
    .res_data    (res_data),
    .ch_en       (ch_en),
    .rd_clr      (reg_rd && reg_sel),
    .conv_rdy    (conv_rdy),
    .cal_rdy     (cal_rdy),
    .cal_wr_en   (cal_wr_en),
    .cal_wr_gain (cal_wr_gain),
    .cal_wr_data (cal_wr_data)
  );

endmodule

// File: rtl/adc_mode_seq_chk.sv
module adc_mode_seq_chk #(
  parameter int NCH = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           conv_pd,
  input logic           conv_rst,
  input logic           res_ready,
  input logic [1:0]     pwr_mode,
  input logic [NCH-1:0] cal_wr_en,
  input logic           cal_rdy,
  input logic           conv_rdy,
  input logic           reg_sel,
  input logic [7:0]     reg_rdata
);

  a_r4_pd_holds_reset: assert property (@(posedge clk) disable iff (!rst_n)
    conv_pd |-> conv_rst);

  a_r12_no_ready_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
    conv_rst |-> !res_ready);

  a_r3_no_bad_power: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_mode != 2'b11);

  a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_sel |-> !reg_rdata[7]);

  a_r7_write_with_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (|cal_wr_en) |-> (cal_rdy && conv_rdy));

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (|cal_wr_en) |=> !(|cal_wr_en));

endmodule

bind adc_mode_seq adc_mode_seq_chk #(.NCH(NCH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .conv_pd   (conv_pd),
  .conv_rst  (conv_rst),
  .res_ready (res_ready),
  .pwr_mode  (pwr_mode),
  .cal_wr_en (cal_wr_en),
  .cal_rdy   (cal_rdy),
  .conv_rdy  (conv_rdy),
  .reg_sel   (reg_sel),
  .reg_rdata (reg_rdata)
);

// File: tb/adc_mode_seq_tb.sv
module adc_mode_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 2;
  localparam int DW  = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 0, reg_rd = 0, reg_sel = 0;
  logic [7:0] reg_wdata = 0;
  logic [7:0] reg_rdata;
  logic res_valid = 0;
  logic res_ready;
  logic [DW-1:0] res_data = 0;
  logic chop_en = 0;
  logic [NCH-1:0] ch_en = 0;
  logic conv_pd, conv_rst, gnd_res_sel, prec_ref_sel;
  logic [1:0] pwr_mode;
  logic [NCH-1:0] cal_wr_en;
  logic cal_wr_gain;
  logic [DW-1:0] cal_wr_data;
  logic conv_rdy, cal_rdy;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_mode_seq #(.NCH(NCH), .DW(DW)) dut_i (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr_mode(input logic [7:0] v);
    @(negedge clk);
    reg_wr = 1; reg_wdata = v;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd_mode(output logic [7:0] v);
    reg_sel = 0; #1 v = reg_rdata;
  endtask

  task automatic rd_status(output logic [7:0] v);
    @(negedge clk);
    reg_sel = 1; reg_rd = 1; #1 v = reg_rdata;
    @(negedge clk);
    reg_rd = 0; reg_sel = 0;
  endtask

  task automatic send(input logic [DW-1:0] d);
    @(negedge clk);
    res_valid = 1; res_data = d;
    @(negedge clk);
    res_valid = 0;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    rd_mode(v);
    check("R1 reset mode", v, 8'h00);
    check("R4 pd in reset", {conv_pd, conv_rst}, 2'b11);
    rd_status(v);
    check("R10 reset status", v, 8'h00);
  endtask

  task automatic t_fields;
    logic [7:0] v;
    wr_mode(8'hFF);
    rd_mode(v);
    check("R1 R3 write FF", v, 8'h67);
    check("R2 outs", {gnd_res_sel, prec_ref_sel}, 2'b11);
    wr_mode(8'h0B);
    check("R3 pwr low", pwr_mode, 2'b01);
    check("R4 idle ctl", {conv_pd, conv_rst}, 2'b01);
    wr_mode(8'h18);
    rd_mode(v);
    check("R3 keep pwr", v, 8'h08);
    check("R2 outs clear", {gnd_res_sel, prec_ref_sel}, 2'b00);
    wr_mode(8'h12);
    check("R3 pwr plus", pwr_mode, 2'b10);
    check("R4 run ctl", {conv_pd, conv_rst}, 2'b00);
    wr_mode(8'h03);
  endtask

  task automatic t_single(input logic chop, input int n);
    logic [7:0] v;
    chop_en = chop;
    wr_mode(8'h02);
    for (int i = 0; i < n - 1; i++) send(24'h10 + i);
    rd_mode(v);
    check("R5 still single", v, 8'h02);
    send(24'h99);
    rd_mode(v);
    check("R5 back idle", v, 8'h03);
    rd_status(v);
    check("R5 R10 conv ready", v, 8'h01);
    rd_status(v);
    check("R10 cleared", v, 8'h00);
    chop_en = 0;
  endtask

  task automatic t_cont;
    logic [7:0] v;
    wr_mode(8'h01);
    for (int i = 0; i < 5; i++) begin
      send(24'h1);
      rd_mode(v);
      check("R6 stays cont", v, 8'h01);
      rd_status(v);
      check("R6 conv rdy each", v, 8'h01);
    end
    wr_mode(8'h03);
  endtask

  task automatic t_cal(input logic [7:0] op, input logic chop, input int n, input logic gain, input string tag);
    logic [7:0] v;
    chop_en = chop;
    ch_en = 2'b10;
    wr_mode(op);
    for (int i = 0; i < n - 1; i++) begin
      send(24'h100 + i);
      check({tag, " no early write"}, cal_wr_en, 2'b00);
    end
    send(24'hABCDE);
    check({tag, " wr_en"}, cal_wr_en, 2'b10);
    check({tag, " gain sel"}, cal_wr_gain, gain);
    check({tag, " data"}, cal_wr_data, 24'hABCDE);
    rd_mode(v);
    check({tag, " idle"}, v, 8'h03);
    rd_status(v);
    check({tag, " flags"}, v, 8'h03);
    chop_en = 0;
    ch_en = 0;
  endtask

  task automatic t_abort;
    logic [7:0] v;
    wr_mode(8'h02);
    send(24'h1);
    wr_mode(8'h02);
    send(24'h2);
    rd_mode(v);
    check("R11 restarted", v, 8'h02);
    send(24'h3);
    rd_mode(v);
    check("R11 completes", v, 8'h03);
    rd_status(v);
  endtask

  task automatic t_ready;
    logic [7:0] v;
    check("R12 not ready idle", res_ready, 1'b0);
    send(24'h5);
    rd_status(v);
    check("R12 idle ignores", v, 8'h00);
    wr_mode(8'h00);
    check("R12 not ready pd", res_ready, 1'b0);
    send(24'h5);
    rd_mode(v);
    check("R12 pd ignores", v, 8'h00);
    wr_mode(8'h02);
    @(negedge clk);
    reg_wr = 1; reg_wdata = 8'h02; #1;
    check("R12 ready low on write", res_ready, 1'b0);
    @(negedge clk);
    reg_wr = 0;
    wr_mode(8'h03);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_fields();
    t_single(1'b0, 2);
    t_single(1'b1, 3);
    t_cont();
    t_cal(8'h04, 1'b0, 2, 1'b0, "R7 offset");
    t_cal(8'h04, 1'b1, 3, 1'b0, "R7 offset chop");
    t_cal(8'h05, 1'b0, 4, 1'b1, "R8 self gain");
    t_cal(8'h07, 1'b1, 6, 1'b1, "R8 full scale");
    t_cal(8'h06, 1'b0, 3, 1'b0, "R9 zero");
    t_cal(8'h06, 1'b1, 3, 1'b0, "R9 zero chop");
    t_abort();
    t_ready();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule